// File: doc/BRIEF.md
# Tag-Renamed Register Status File

This block is the architectural register file of a dynamically scheduled core. Each entry is either ready, holding a committed value, or pending, holding the tag of the reservation station that will produce the value. At issue, an instruction reads its two sources through two combinational read ports. Each port returns a ready flag together with either the value or the tag to wait on. The same instruction then renames its destination through the rename port by writing the tag of the station it was given.

There is no indexed data write port. A pending entry gets its value only by snooping the common result bus. When the bus carries the tag the entry is waiting on, the entry takes the bus value and becomes ready. Every entry waiting on that tag does this in the same cycle. A later rename replaces an older pending tag, so a late result from a superseded producer is ignored. Tag 0 means "no producer", and station tags run from 1 to `NUM_TAGS`. A read in the same cycle as a matching broadcast is bypassed.

Top module: `regstat_file`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register reads ready=1, value=0, tag=0 until it is renamed.
- R2: `ren_en`=1 with a nonzero `ren_tag` makes register `ren_idx` pending on that tag from the next cycle. A read then returns ready=0, tag=`ren_tag`, value=0.
- R3: A bus cycle (`cdb_valid`=1) whose `cdb_tag` equals a pending register's tag makes that register ready with value `cdb_value` from the next cycle.
- R4: A later rename of a pending register replaces its tag. A broadcast of the superseded tag leaves the register pending on the newer tag.
- R5: When a rename and a matching broadcast hit the same register in one cycle, the rename wins. The register is pending on the new tag in the next cycle.
- R6: A read of a pending register in the same cycle as a broadcast of its tag returns ready=1 and value=`cdb_value`.
- R7: Tag 0 is reserved. A rename with `ren_tag`=0 changes nothing, and a broadcast with `cdb_tag`=0 changes nothing.
- R8: One broadcast completes every register pending on its tag, in the same cycle.
- R9: A read of the register being renamed in the same cycle returns its state before the rename.
- R10: A ready register always reads tag=0, and a pending register always reads value=0 with a nonzero tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rda_idx | input | IDX_W | Source A register index |
| rda_ready | output | 1 | Source A holds a real value |
| rda_value | output | DATA_W | Source A value (0 when pending) |
| rda_tag | output | TAG_W | Source A producer tag (0 when ready) |
| rdb_idx | input | IDX_W | Source B register index |
| rdb_ready | output | 1 | Source B holds a real value |
| rdb_value | output | DATA_W | Source B value (0 when pending) |
| rdb_tag | output | TAG_W | Source B producer tag (0 when ready) |
| ren_en | input | 1 | Rename request |
| ren_idx | input | IDX_W | Destination register to rename |
| ren_tag | input | TAG_W | New producer tag |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the producing station |
| cdb_value | input | DATA_W | Result value |

## Verification
The bench builds the block with eight registers, 16-bit data and only three station tags. With so few tags, random broadcasts often match a pending register. The same small tag space also means several registers end up waiting on one tag, and re-renames often leave a stale tag still in flight. That brings fan-out completion, superseded-result rejection and rename-versus-broadcast collisions within easy reach of random stimulus. Directed sequences add the exact collision cases.

// File: rtl/regstat_pkg.sv
package regstat_pkg;
  function automatic int tag_bits(input int n_tags);
    return (n_tags < 1) ? 1 : $clog2(n_tags + 1);
  endfunction

  function automatic int idx_bits(input int n_regs);
    return (n_regs < 2) ? 1 : $clog2(n_regs);
  endfunction
endpackage

// File: rtl/regstat_entry.sv
module regstat_entry #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_hit,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              busy_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic [DATA_W-1:0] value_q
);
  logic              cap_hit;
  logic              upd_en;
  logic              busy_d;
  logic [TAG_W-1:0]  tag_d;
  logic [DATA_W-1:0] value_d;

  always_comb begin
    cap_hit = busy_q && cdb_valid && (cdb_tag == tag_q);
    upd_en  = ren_hit || cap_hit;
    busy_d  = busy_q;
    tag_d   = tag_q;
    value_d = value_q;
    if (ren_hit) begin
      busy_d = 1'b1;
      tag_d  = ren_tag;
    end else if (cap_hit) begin
      busy_d  = 1'b0;
      tag_d   = '0;
      value_d = cdb_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tag_q   <= '0;
      value_q <= '0;
    end else if (upd_en) begin
      busy_q  <= busy_d;
      tag_q   <= tag_d;
      value_q <= value_d;
    end
  end

  // R3: matching broadcast completes the entry
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cdb_valid && cdb_tag == tag_q && !ren_hit)
      |=> (!busy_q && value_q == $past(cdb_value)));

  // R4: no rename and no matching broadcast keeps the pending tag
  a_r4_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ren_hit && !(cdb_valid && cdb_tag == tag_q))
      |=> (busy_q && tag_q == $past(tag_q)));

  // R5: rename wins over a same-cycle broadcast
  a_r5_rename_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ren_hit |=> (busy_q && tag_q == $past(ren_tag)));

  // R10: a pending entry never holds the reserved tag
  a_r10_pending_tag: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tag_q != '0));
endmodule

// File: rtl/regstat_rdport.sv
module regstat_rdport #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              ent_busy,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [DATA_W-1:0] ent_value,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_value,
  output logic [TAG_W-1:0]  rd_tag
);
  logic byp_hit;

  always_comb begin
    byp_hit = ent_busy && cdb_valid && (cdb_tag == ent_tag);
    if (byp_hit) begin
      rd_ready = 1'b1;
      rd_value = cdb_value;
      rd_tag   = '0;
    end else if (ent_busy) begin
      rd_ready = 1'b0;
      rd_value = '0;
      rd_tag   = ent_tag;
    end else begin
      rd_ready = 1'b1;
      rd_value = ent_value;
      rd_tag   = '0;
    end
  end
endmodule

// File: rtl/regstat_file.sv
module regstat_file
  import regstat_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_TAGS = 4,
  localparam int IDX_W   = idx_bits(NUM_REGS),
  localparam int TAG_W   = tag_bits(NUM_TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic              rda_ready,
  output logic [DATA_W-1:0] rda_value,
  output logic [TAG_W-1:0]  rda_tag,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic              rdb_ready,
  output logic [DATA_W-1:0] rdb_value,
  output logic [TAG_W-1:0]  rdb_tag,
  input  logic              ren_en,
  input  logic [IDX_W-1:0]  ren_idx,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value
);
  logic [NUM_REGS-1:0] busy_vec;
  logic [TAG_W-1:0]    tag_arr   [NUM_REGS];
  logic [DATA_W-1:0]   value_arr [NUM_REGS];
  logic [NUM_REGS-1:0] ren_hit_vec;
  logic                ren_live;

  assign ren_live = ren_en && (ren_tag != '0);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ent
    assign ren_hit_vec[gi] = ren_live && (ren_idx == IDX_W'(gi));
    regstat_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .ren_hit   (ren_hit_vec[gi]),
      .ren_tag   (ren_tag),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value),
      .busy_q    (busy_vec[gi]),
      .tag_q     (tag_arr[gi]),
      .value_q   (value_arr[gi])
    );
  end

  localparam int NPORT = 2;
  logic [IDX_W-1:0]  sel_idx   [NPORT];
  logic              sel_busy  [NPORT];
  logic [TAG_W-1:0]  sel_tag   [NPORT];
  logic [DATA_W-1:0] sel_value [NPORT];
  logic              out_ready [NPORT];
  logic [DATA_W-1:0] out_value [NPORT];
  logic [TAG_W-1:0]  out_tag   [NPORT];

  assign sel_idx[0] = rda_idx;
  assign sel_idx[1] = rdb_idx;

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    always_comb begin
      sel_busy[gp]  = 1'b0;
      sel_tag[gp]   = '0;
      sel_value[gp] = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
        if (sel_idx[gp] == IDX_W'(k)) begin
          sel_busy[gp]  = busy_vec[k];
          sel_tag[gp]   = tag_arr[k];
          sel_value[gp] = value_arr[k];
        end
      end
    end

    regstat_rdport #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_rd (
      .ent_busy  (sel_busy[gp]),
      .ent_tag   (sel_tag[gp]),
      .ent_value (sel_value[gp]),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value),
      .rd_ready  (out_ready[gp]),
      .rd_value  (out_value[gp]),
      .rd_tag    (out_tag[gp])
    );
  end

  assign rda_ready = out_ready[0];
  assign rda_value = out_value[0];
  assign rda_tag   = out_tag[0];
  assign rdb_ready = out_ready[1];
  assign rdb_value = out_value[1];
  assign rdb_tag   = out_tag[1];

  // R7: a rename with the reserved tag leaves pending state untouched
  a_r7_zero_rename: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_en && ren_tag == '0 && !cdb_valid) |=> $stable(busy_vec));

  // R10: read port outputs agree with the ready flag
  a_r10_port_a: assert property (@(posedge clk) disable iff (!rst_n)
    rda_ready ? (rda_tag == '0) : (rda_tag != '0 && rda_value == '0));
  a_r10_port_b: assert property (@(posedge clk) disable iff (!rst_n)
    rdb_ready ? (rdb_tag == '0) : (rdb_tag != '0 && rdb_value == '0));
endmodule

// File: tb/sim_regstat_file.sv
module sim_regstat_file;
  localparam int NR = 8;
  localparam int DW = 16;
  localparam int NT = 3;
  localparam int IW = 3;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] rda_idx = '0, rdb_idx = '0, ren_idx = '0;
  logic          rda_ready, rdb_ready;
  logic [DW-1:0] rda_value, rdb_value;
  logic [TW-1:0] rda_tag, rdb_tag;
  logic          ren_en = 1'b0, cdb_valid = 1'b0;
  logic [TW-1:0] ren_tag = '0, cdb_tag = '0;
  logic [DW-1:0] cdb_value = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          m_busy [NR];
  logic [TW-1:0] m_tag  [NR];
  logic [DW-1:0] m_val  [NR];

  always #4 clk = ~clk;

  regstat_file #(.NUM_REGS(NR), .DATA_W(DW), .NUM_TAGS(NT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rda_idx(rda_idx), .rda_ready(rda_ready), .rda_value(rda_value), .rda_tag(rda_tag),
    .rdb_idx(rdb_idx), .rdb_ready(rdb_ready), .rdb_value(rdb_value), .rdb_tag(rdb_tag),
    .ren_en(ren_en), .ren_idx(ren_idx), .ren_tag(ren_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value));

  function automatic logic [DW+TW:0] exp_read(input int i);
    if (m_busy[i] && cdb_valid && cdb_tag == m_tag[i]) return {1'b1, cdb_value, {TW{1'b0}}};
    if (m_busy[i]) return {1'b0, {DW{1'b0}}, m_tag[i]};
    return {1'b1, m_val[i], {TW{1'b0}}};
  endfunction

  task automatic check_port(input string req, input int port);
    logic [DW+TW:0] got, exp;
    int idx;
    idx = (port == 0) ? int'(rda_idx) : int'(rdb_idx);
    got = (port == 0) ? {rda_ready, rda_value, rda_tag} : {rdb_ready, rdb_value, rdb_tag};
    exp = exp_read(idx);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s port%0d reg%0d actual rdy=%0b val=%0h tag=%0d expected rdy=%0b val=%0h tag=%0d",
               req, port, idx, got[DW+TW], got[DW+TW-1:TW], got[TW-1:0],
               exp[DW+TW], exp[DW+TW-1:TW], exp[TW-1:0]);
    end
  endtask

  // drive one cycle, check both ports before the edge, advance the model at the edge
  task automatic step(input string req, input int ra, input int rb,
                      input bit ren, input int ri, input int rt,
                      input bit cv, input int ct, input int cval);
    logic          n_busy [NR];
    logic [TW-1:0] n_tag  [NR];
    logic [DW-1:0] n_val  [NR];
    @(negedge clk);
    rda_idx = IW'(ra); rdb_idx = IW'(rb);
    ren_en = ren; ren_idx = IW'(ri); ren_tag = TW'(rt);
    cdb_valid = cv; cdb_tag = TW'(ct); cdb_value = DW'(cval);
    #2;
    check_port(req, 0);
    check_port(req, 1);
    for (int i = 0; i < NR; i++) begin
      n_busy[i] = m_busy[i]; n_tag[i] = m_tag[i]; n_val[i] = m_val[i];
      if (ren && rt != 0 && ri == i) begin
        n_busy[i] = 1'b1; n_tag[i] = TW'(rt);
      end else if (m_busy[i] && cv && TW'(ct) == m_tag[i]) begin
        n_busy[i] = 1'b0; n_tag[i] = '0; n_val[i] = DW'(cval);
      end
    end
    @(posedge clk);
    for (int i = 0; i < NR; i++) begin
      m_busy[i] = n_busy[i]; m_tag[i] = n_tag[i]; m_val[i] = n_val[i];
    end
  endtask

  task automatic idle_read(input string req, input int ra, input int rb);
    step(req, ra, rb, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin
      m_busy[i] = 1'b0; m_tag[i] = '0; m_val[i] = '0;
    end
    #3;
    check_port("R1", 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: every register ready with value 0 after reset
    for (int i = 0; i < NR; i += 2) idle_read("R1", i, i + 1);

    // R2 / R9: rename reg2 to tag1, read in the same cycle sees old state, then pending
    step("R9", 2, 3, 1, 2, 1, 0, 0, 0);
    idle_read("R2", 2, 3);
    // R3 / R6: broadcast tag1 bypassed in same cycle, captured next cycle
    step("R6", 2, 2, 0, 0, 0, 1, 1, 16'hBEEF);
    idle_read("R3", 2, 0);

    // R4: rename reg4 to tag1 then to tag2, broadcast tag1 must be ignored
    step("R2", 4, 4, 1, 4, 1, 0, 0, 0);
    step("R4", 4, 4, 1, 4, 2, 0, 0, 0);
    step("R4", 4, 4, 0, 0, 0, 1, 1, 16'h1111);
    idle_read("R4", 4, 4);
    step("R3", 4, 4, 0, 0, 0, 1, 2, 16'h2222);
    idle_read("R3", 4, 4);

    // R5: reg5 pending on tag3, rename to tag1 while tag3 broadcasts
    step("R2", 5, 5, 1, 5, 3, 0, 0, 0);
    step("R5", 5, 5, 1, 5, 1, 1, 3, 16'h3333);
    idle_read("R5", 5, 6);

    // R7: rename with tag 0 ignored; broadcast with tag 0 ignored
    step("R7", 6, 6, 1, 6, 0, 0, 0, 0);
    idle_read("R7", 6, 6);
    step("R7", 5, 6, 0, 0, 0, 1, 0, 16'h7777);
    idle_read("R7", 5, 6);

    // R8: regs 0 and 7 both wait on tag2, one broadcast completes both
    step("R2", 0, 7, 1, 0, 2, 0, 0, 0);
    step("R2", 0, 7, 1, 7, 2, 0, 0, 0);
    step("R8", 0, 7, 0, 0, 0, 1, 2, 16'hA5A5);
    idle_read("R8", 0, 7);
    step("R10", 5, 0, 0, 0, 0, 1, 1, 16'h0F0F);
    idle_read("R10", 5, 1);

    // random traffic
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      step("R10", int'($urandom_range(NR - 1)), int'($urandom_range(NR - 1)),
           bit'($urandom_range(1)), int'($urandom_range(NR - 1)), int'($urandom_range(NT)),
           bit'($urandom_range(1)), int'($urandom_range(NT)), int'($urandom_range(16'hFFFF)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule